// File: doc/BRIEF.md
# Secondary Bus Reset Sequencer

This block drives the reset of a bridge's downstream bus and the internal resets of the bridge's secondary clock domain. The downstream reset is held while the upstream reset is low or while a software reset control bit is set. When both are released, the sequencer waits for a clock-stable indication and then runs a settle timer. During that timer the bus mode is detected. The mode is captured when the timer expires, and the downstream reset is released a fixed number of secondary clock cycles later.

What happens next depends on the captured mode. In PCI-X mode, the PLL reset is released when the mode is captured, and the internal logic reset is held for a lock interval after the bus reset is released. In conventional PCI mode, the PLL stays in reset and in bypass, and the internal logic reset is held for a few more secondary clock cycles.

All microsecond delays are counted on a free-running reference clock. Secondary clock cycles arrive as a one-cycle `sec_tick` pulse, synchronous to that reference clock. The clock-stable and mode inputs each pass through a two-flop synchronizer.

Top module: `sec_reset_seq`

## Requirements
- R1: While `up_rst_n` is low, `sec_rst_n`=0, `logic_rst`=1, `pll_rst`=1 and `seq_state`=0. This takes effect at once, without waiting for a clock edge.
- R2: One clock after `sw_rst_bit` is sampled high, `sec_rst_n`=0 and `seq_state`=0. They stay that way for as long as the bit remains 1.
- R3: After both resets are released, the sequencer moves from state 0 to state 1. It stays in state 1 until the synchronized `clk_stable` (two flops of delay) is seen high.
- R4: The settle state (2) lasts exactly SETTLE_US*REF_CYC_PER_US reference cycles. The synchronized `mode_pcix` is captured on the last of those cycles.
- R5: The hold state (3) ends on the HOLD_TICKS-th `sec_tick`. `sec_rst_n` rises on that same edge.
- R6: In PCI-X mode (captured mode = 1):
  - `pll_rst` and `pll_bypass` fall on entry to state 3.
  - The lock state (4) lasts LOCK_US*REF_CYC_PER_US reference cycles.
  - After that, `logic_rst` falls and the sequencer reaches state 6.
- R7: In PCI mode (captured mode = 0):
  - `pll_rst` and `pll_bypass` stay 1 throughout.
  - The tail state (5) ends on the TAIL_TICKS-th `sec_tick`.
  - After that, `logic_rst` falls and the sequencer reaches state 6.
- R8: `ad_drive_low` and `ctl_tristate` are 1 exactly when `sec_rst_n` is 0.
- R9: If `sw_rst_bit` is raised in any state, the sequencer returns to state 0 and replays the whole sequence from the start.
- R10: `seq_state` encodes the states as follows: 0 reset, 1 wait-stable, 2 settle, 3 hold, 4 lock, 5 tail, 6 done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock |
| up_rst_n | input | 1 | Upstream reset, active low, asynchronous |
| sw_rst_bit | input | 1 | Software secondary-reset control bit |
| clk_stable | input | 1 | Secondary clock stable indication (asynchronous) |
| mode_pcix | input | 1 | Mode-detect result, 1 = PCI-X (asynchronous) |
| sec_tick | input | 1 | One pulse per secondary clock cycle |
| sec_rst_n | output | 1 | Downstream bus reset, active low |
| pll_rst | output | 1 | Internal PLL reset |
| pll_bypass | output | 1 | PLL bypass select |
| logic_rst | output | 1 | Secondary-domain logic reset |
| ad_drive_low | output | 1 | Drive address/data and byte enables low |
| ctl_tristate | output | 1 | Tri-state the other bus control lines |
| seq_state | output | 3 | Current sequencer state |

## Verification
The embedded assertions check several properties on every cycle:
- A set control bit forces the sequencer back to reset.
- The settle timer never starts without a synchronized stable indication.
- The bus reset rises only on a secondary tick.
- The PLL reset falls only in PCI-X mode.
- The logic reset is never released ahead of the bus reset.

Exact durations, the point at which the mode is captured, and restarts from the middle of the sequence can be shown only by the bench scenarios. Those scenarios compare every output against a behavioural model on every cycle.

// File: rtl/sec_reset_seq.sv
module sec_reset_seq #(
  parameter int REF_CYC_PER_US = 25,
  parameter int SETTLE_US      = 100,
  parameter int LOCK_US        = 100,
  parameter int HOLD_TICKS     = 10,
  parameter int TAIL_TICKS     = 5
) (
  input  logic       ref_clk,
  input  logic       up_rst_n,
  input  logic       sw_rst_bit,
  input  logic       clk_stable,
  input  logic       mode_pcix,
  input  logic       sec_tick,
  output logic       sec_rst_n,
  output logic       pll_rst,
  output logic       pll_bypass,
  output logic       logic_rst,
  output logic       ad_drive_low,
  output logic       ctl_tristate,
  output logic [2:0] seq_state
);
  localparam int SETTLE_CYC = SETTLE_US * REF_CYC_PER_US;
  localparam int LOCK_CYC   = LOCK_US * REF_CYC_PER_US;
  localparam int MAX_A = (SETTLE_CYC > LOCK_CYC) ? SETTLE_CYC : LOCK_CYC;
  localparam int MAX_B = (HOLD_TICKS > TAIL_TICKS) ? HOLD_TICKS : TAIL_TICKS;
  localparam int CW    = $clog2(((MAX_A > MAX_B) ? MAX_A : MAX_B) + 1);

  typedef enum logic [2:0] {
    S_RST = 3'd0, S_WAIT = 3'd1, S_SETTLE = 3'd2, S_HOLD = 3'd3,
    S_LOCK = 3'd4, S_TAIL = 3'd5, S_DONE = 3'd6
  } st_t;

  st_t           st, st_nx;
  logic [CW-1:0] cnt, cnt_nx;
  logic [1:0]    stab_q, mode_q;
  logic          mode_lat;

  wire stab_s      = stab_q[1];
  wire settle_done = (cnt == CW'(SETTLE_CYC - 1));
  wire lock_done   = (cnt == CW'(LOCK_CYC - 1));
  wire hold_done   = sec_tick && (cnt == CW'(HOLD_TICKS - 1));
  wire tail_done   = sec_tick && (cnt == CW'(TAIL_TICKS - 1));

  always_comb begin
    st_nx  = st;
    cnt_nx = cnt;
    if (sw_rst_bit) begin
      st_nx  = S_RST;
      cnt_nx = '0;
    end else begin
      case (st)
        S_RST:  begin st_nx = S_WAIT; cnt_nx = '0; end
        S_WAIT: if (stab_s) begin st_nx = S_SETTLE; cnt_nx = '0; end
        S_SETTLE:
          if (settle_done) begin st_nx = S_HOLD; cnt_nx = '0; end
          else cnt_nx = cnt + 1'b1;
        S_HOLD:
          if (hold_done) begin
            st_nx  = mode_lat ? S_LOCK : S_TAIL;
            cnt_nx = '0;
          end else if (sec_tick) cnt_nx = cnt + 1'b1;
        S_LOCK:
          if (lock_done) st_nx = S_DONE;
          else cnt_nx = cnt + 1'b1;
        S_TAIL:
          if (tail_done) st_nx = S_DONE;
          else if (sec_tick) cnt_nx = cnt + 1'b1;
        default: st_nx = st;
      endcase
    end
  end

  always_ff @(posedge ref_clk or negedge up_rst_n) begin
    if (!up_rst_n) begin
      st       <= S_RST;
      cnt      <= '0;
      mode_lat <= 1'b0;
      stab_q   <= 2'b00;
      mode_q   <= 2'b00;
    end else begin
      stab_q <= {stab_q[0], clk_stable};
      mode_q <= {mode_q[0], mode_pcix};
      st     <= st_nx;
      cnt    <= cnt_nx;
      if (!sw_rst_bit && st == S_SETTLE && settle_done) mode_lat <= mode_q[1];
    end
  end

  wire pll_run = mode_lat && (st == S_HOLD || st == S_LOCK || st == S_DONE);

  assign sec_rst_n    = (st == S_LOCK) || (st == S_TAIL) || (st == S_DONE);
  assign logic_rst    = (st != S_DONE);
  assign pll_rst      = !pll_run;
  assign pll_bypass   = !pll_run;
  assign ad_drive_low = !sec_rst_n;
  assign ctl_tristate = !sec_rst_n;
  assign seq_state    = st;

  AST_SW_FORCES_RESET: assert property (@(posedge ref_clk) disable iff (!up_rst_n)
    sw_rst_bit |=> (seq_state == 3'd0 && !sec_rst_n)); // R2
  AST_TIMER_GATED: assert property (@(posedge ref_clk) disable iff (!up_rst_n)
    (seq_state == 3'd2 && $past(seq_state) == 3'd1) |-> $past(stab_s)); // R3
  AST_RELEASE_ON_TICK: assert property (@(posedge ref_clk) disable iff (!up_rst_n)
    $rose(sec_rst_n) |-> $past(sec_tick)); // R5
  AST_PLL_ONLY_PCIX: assert property (@(posedge ref_clk) disable iff (!up_rst_n)
    $fell(pll_rst) |-> mode_lat); // R6
  AST_LOGIC_AFTER_BUS: assert property (@(posedge ref_clk) disable iff (!up_rst_n)
    !logic_rst |-> sec_rst_n); // R7
  AST_RESTART_ANY: assert property (@(posedge ref_clk) disable iff (!up_rst_n)
    (sw_rst_bit && seq_state != 3'd0) |=> !sec_rst_n && logic_rst); // R9
endmodule

// File: tb/sec_reset_seq_test.sv
module sec_reset_seq_test;
  localparam int PERIOD = 10;
  localparam int RPU = 1, SUS = 20, LUS = 15, HT = 10, TT = 5;

  logic ref_clk = 0, up_rst_n = 0, sw_rst_bit = 0, clk_stable = 0, mode_pcix = 0, sec_tick = 0;
  logic sec_rst_n, pll_rst, pll_bypass, logic_rst, ad_drive_low, ctl_tristate;
  logic [2:0] seq_state;

  sec_reset_seq #(.REF_CYC_PER_US(RPU), .SETTLE_US(SUS), .LOCK_US(LUS),
                  .HOLD_TICKS(HT), .TAIL_TICKS(TT)) uut (
    .ref_clk(ref_clk), .up_rst_n(up_rst_n), .sw_rst_bit(sw_rst_bit),
    .clk_stable(clk_stable), .mode_pcix(mode_pcix), .sec_tick(sec_tick),
    .sec_rst_n(sec_rst_n), .pll_rst(pll_rst), .pll_bypass(pll_bypass),
    .logic_rst(logic_rst), .ad_drive_low(ad_drive_low),
    .ctl_tristate(ctl_tristate), .seq_state(seq_state));

  always #(PERIOD/2) ref_clk = ~ref_clk;

  int vectors = 0, errors = 0, tick_div = 1, tcount = 0;
  int m_st = 0, m_cnt = 0, m_ml = 0, s1 = 0, s2 = 0, d1 = 0, d2 = 0;
  string cur_req = "R1";
  bit finished = 0;

  always @(posedge ref_clk or negedge up_rst_n) begin
    if (!up_rst_n) begin
      m_st = 0; m_cnt = 0; m_ml = 0; s1 = 0; s2 = 0; d1 = 0; d2 = 0;
    end else begin
      if (sw_rst_bit) begin m_st = 0; m_cnt = 0; end
      else case (m_st)
        0: begin m_st = 1; m_cnt = 0; end
        1: if (s2 != 0) begin m_st = 2; m_cnt = 0; end
        2: if (m_cnt == SUS*RPU - 1) begin m_st = 3; m_cnt = 0; m_ml = d2; end
           else m_cnt++;
        3: if (sec_tick) begin
             if (m_cnt == HT - 1) begin m_st = (m_ml != 0) ? 4 : 5; m_cnt = 0; end
             else m_cnt++;
           end
        4: if (m_cnt == LUS*RPU - 1) m_st = 6; else m_cnt++;
        5: if (sec_tick) begin
             if (m_cnt == TT - 1) m_st = 6; else m_cnt++;
           end
        default: ;
      endcase
      s2 = s1; s1 = clk_stable;
      d2 = d1; d1 = mode_pcix;
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s/%s actual=%b expected=%b t=%0t", cur_req, tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic e_rel, e_pll;
    e_rel = (m_st == 4 || m_st == 5 || m_st == 6);
    e_pll = !(m_ml != 0 && (m_st == 3 || m_st == 4 || m_st == 6));
    vectors++;
    if (seq_state !== 3'(m_st)) begin
      errors++;
      $display("FAIL %s/R10 state actual=%0d expected=%0d t=%0t", cur_req, seq_state, m_st, $time);
    end
    chk("R5 sec_rst_n", sec_rst_n, e_rel);
    chk("R6 pll_rst", pll_rst, e_pll);
    chk("R6 pll_bypass", pll_bypass, e_pll);
    chk("R7 logic_rst", logic_rst, m_st != 6);
    chk("R8 ad_drive_low", ad_drive_low, !e_rel);
    chk("R8 ctl_tristate", ctl_tristate, !e_rel);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge ref_clk);
      compare();
      tcount++;
      sec_tick = (tcount % tick_div) == 0;
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    cur_req = "R1";
    run(3);
    up_rst_n = 1;
    cur_req = "R3";
    run(30);
    clk_stable = 1;
    mode_pcix = 1;
    cur_req = "R4";
    run(10);
    mode_pcix = 0;
    run(5);
    mode_pcix = 1;
    cur_req = "R6";
    run(60);
    cur_req = "R2";
    sw_rst_bit = 1;
    run(8);
    sw_rst_bit = 0;
    mode_pcix = 0;
    tick_div = 3;
    cur_req = "R7";
    run(90);
    cur_req = "R9";
    sw_rst_bit = 1;
    run(2);
    sw_rst_bit = 0;
    mode_pcix = 1;
    tick_div = 2;
    run(35);
    sw_rst_bit = 1;
    run(1);
    sw_rst_bit = 0;
    run(70);
    cur_req = "R1";
    @(negedge ref_clk);
    up_rst_n = 0;
    #1;
    compare();
    run(2);
    up_rst_n = 1;
    clk_stable = 0;
    cur_req = "R5";
    tick_div = 4;
    run(6);
    clk_stable = 1;
    run(100);
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule